// File: doc/BRIEF.md
# 4x4 Inverse Transform with Reconstruction

This block turns one 4x4 block of signed 16-bit transform coefficients and the matching 4x4 block of unsigned 8-bit prediction samples into 16 reconstructed 8-bit pixels. The residual comes from a separable two-pass integer inverse transform. The first pass works down the columns and the second pass works along the rows. Each 1-D pass is an even/odd butterfly that uses only the constants 64, 83 and 36. Each pass rounds, shifts and saturates its results back to signed 16 bits. The residual is then added to the prediction and clamped to the pixel range.

A whole coefficient block and its prediction block arrive in one valid/ready transfer. The column pass runs straight from the input port into a middle register. The row pass and the prediction add run from that register into an output register. The output register then sends the pixels one per beat, in raster order, over a second valid/ready interface. A marker flags the last beat of each block. While one block is being sent, the next block can wait in the middle register, so consecutive blocks leave with no idle cycle between them.

Top module: `itx4_recon`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: A block is captured at a clock edge where `in_valid` and `in_ready` are both high. When a block waits in the middle register and the output register still holds undelivered pixels that are not leaving at the next edge, `in_ready` is low.
- R3: Column pass. For each column, let x0..x3 be its rows 0..3. The pass forms e0 = 64(x0+x2), e1 = 64(x0-x2), o0 = 83x1+36x3 and o1 = 36x1-83x3 with at least 32-bit precision. The four outputs in order are e0+o0, e1+o1, e1-o1 and e0-o0. Each output gets 64 added, is shifted arithmetically right by 7, and is saturated to -32768..32767. Output k of column j becomes element (j,k) of the intermediate block, which is a transpose.
- R4: Row pass. The same butterfly is applied to each row of the intermediate block, read back in the original orientation. Each output gets 2048 added, is shifted arithmetically right by 12, and is saturated to -32768..32767. Output m of row i is the residual at row i, column m.
- R5: Each output pixel is the residual plus the co-located prediction sample, computed exactly without wrap, and then clamped to 0..255.
- R6: Pixels leave one per accepted beat in raster order, so element (r,c) is beat 4r+c. `out_last` is high only on beat 15, and a block's beats are never separated by an idle cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_pix` and `out_last` hold their values.
- R8: When the block is idle and `out_ready` is high, the first pixel of a block is valid after the second clock edge following the accepting edge, and not before.
- R9: If a block is waiting in the middle register when the last beat of the previous block is taken, its first pixel is valid in the very next cycle.
- R10: Inside the coefficient port, element (r,c) occupies bits [(4r+c)*16 +: 16]. Inside the prediction port, sample (r,c) occupies bits [(4r+c)*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient and prediction block offered |
| in_ready | output | 1 | Block can be taken at the next edge |
| in_coef | input | 256 | 16 signed 16-bit coefficients, raster packed |
| in_pred | input | 128 | 16 unsigned 8-bit prediction samples, raster packed |
| out_valid | output | 1 | `out_pix` holds a pixel |
| out_ready | input | 1 | Sink takes the pixel at the next edge |
| out_pix | output | 8 | Reconstructed pixel |
| out_last | output | 1 | Beat 15 of the current block |

## Verification
Two things can happen at the same edge. The last pixel of one block can be taken at the edge where the next block moves from the middle register into the output register, and a fresh block can enter at that same edge. The bench sets this up by sending blocks back to back with `out_ready` held high, and again with `out_ready` toggling at random. Whenever the scoreboard still holds a captured block at the moment a last beat leaves, the bench requires `out_valid` in the next cycle. Every popped pixel is also compared against an independent integer model of both passes, so a lost, repeated or reordered block shows up as a miscompare.

// File: rtl/itx4_pkg.sv
package itx4_pkg;
  localparam int DIM       = 4;
  localparam int NUM       = DIM * DIM;
  localparam int COEF_W    = 16;
  localparam int PIX_W     = 8;
  localparam int ACC_W     = 32;
  localparam int SHIFT_COL = 7;
  localparam int SHIFT_ROW = 12;
  localparam int EVEN_SH   = 6;   // even weight 64 as a shift
  localparam int K_ODD_HI  = 83;
  localparam int K_ODD_LO  = 36;
  localparam int DIM_W     = $clog2(DIM);
  localparam int BEAT_W    = 2 * DIM_W;

  typedef logic [DIM-1:0][COEF_W-1:0]          cline_t;
  typedef logic [DIM-1:0][DIM-1:0][COEF_W-1:0] cblk_t;
  typedef logic [DIM-1:0][DIM-1:0][PIX_W-1:0]  pblk_t;
endpackage

// File: rtl/itx4_bfly.sv
// One 1-D line of the inverse transform: even/odd butterfly, round, shift, saturate.
module itx4_bfly
  import itx4_pkg::*;
#(
  parameter int SHIFT = SHIFT_COL
) (
  input  cline_t x,
  output cline_t y
);
  localparam logic signed [ACC_W-1:0] C_HI   = ACC_W'(K_ODD_HI);
  localparam logic signed [ACC_W-1:0] C_LO   = ACC_W'(K_ODD_LO);
  localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (COEF_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -(ACC_W'(1) <<< (COEF_W - 1));

  logic signed [ACC_W-1:0] a [DIM];
  logic signed [ACC_W-1:0] s [DIM];
  logic signed [ACC_W-1:0] ev_sum, ev_dif, od_a, od_b;

  for (genvar r = 0; r < DIM; r++) begin : g_ext
    assign a[r] = {{(ACC_W - COEF_W){x[r][COEF_W-1]}}, x[r]};
  end

  assign ev_sum = (a[0] + a[2]) <<< EVEN_SH;
  assign ev_dif = (a[0] - a[2]) <<< EVEN_SH;
  assign od_a   = C_HI * a[1] + C_LO * a[3];
  assign od_b   = C_LO * a[1] - C_HI * a[3];

  assign s[0] = ev_sum + od_a;
  assign s[1] = ev_dif + od_b;
  assign s[2] = ev_dif - od_b;
  assign s[3] = ev_sum - od_a;

  for (genvar k = 0; k < DIM; k++) begin : g_out
    logic signed [ACC_W-1:0] rounded;
    logic signed [ACC_W-1:0] scaled;
    assign rounded = s[k] + RND;
    assign scaled  = rounded >>> SHIFT;
    always_comb begin
      if (scaled > SAT_HI)      y[k] = SAT_HI[COEF_W-1:0];
      else if (scaled < SAT_LO) y[k] = SAT_LO[COEF_W-1:0];
      else                      y[k] = scaled[COEF_W-1:0];
    end
  end
endmodule

// File: rtl/itx4_stage.sv
// One pass over a 4x4 block: line j reads column j of din and writes row j of dout.
module itx4_stage
  import itx4_pkg::*;
#(
  parameter int SHIFT = SHIFT_COL
) (
  input  cblk_t din,
  output cblk_t dout
);
  for (genvar j = 0; j < DIM; j++) begin : g_line
    cline_t xl;
    cline_t yl;
    for (genvar r = 0; r < DIM; r++) begin : g_pick
      assign xl[r] = din[r][j];
    end
    itx4_bfly #(.SHIFT(SHIFT)) u_bfly (
      .x(xl),
      .y(yl)
    );
    assign dout[j] = yl;
  end
endmodule

// File: rtl/itx4_recon_add.sv
// Residual plus prediction, clamped to the unsigned pixel range.
module itx4_recon_add
  import itx4_pkg::*;
(
  input  cblk_t res,
  input  pblk_t pred,
  output pblk_t pix
);
  localparam int SUM_W = COEF_W + 1;
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      logic signed [SUM_W-1:0] sum;
      assign sum = $signed({res[r][c][COEF_W-1], res[r][c]})
                 + $signed({{(SUM_W - PIX_W){1'b0}}, pred[r][c]});
      always_comb begin
        if (sum < 0)            pix[r][c] = '0;
        else if (sum > PIX_MAX) pix[r][c] = PIX_MAX[PIX_W-1:0];
        else                    pix[r][c] = sum[PIX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/itx4_serializer.sv
// Output register: holds one reconstructed block and sends it pixel by pixel.
module itx4_serializer
  import itx4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  pblk_t            din,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_last,
  output logic             free
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM - 1);

  logic              valid_q, valid_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  pblk_t             hold_q;
  logic              hold_en;

  assign hold_en   = load;
  assign free      = !valid_q || (out_ready && (beat_q == LAST_BEAT));
  assign out_valid = valid_q;
  assign out_last  = valid_q && (beat_q == LAST_BEAT);
  assign out_pix   = hold_q[beat_q[BEAT_W-1:DIM_W]][beat_q[DIM_W-1:0]];

  always_comb begin
    valid_d = valid_q;
    beat_d  = beat_q;
    if (load) begin
      valid_d = 1'b1;
      beat_d  = '0;
    end else if (valid_q && out_ready) begin
      beat_d = beat_q + BEAT_W'(1);
      if (beat_q == LAST_BEAT) valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      valid_q <= valid_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= din;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_last))); // R7
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid); // R6
  AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid || (beat_q == '0))); // R6
endmodule

// File: rtl/itx4_recon.sv
module itx4_recon
  import itx4_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NUM*COEF_W-1:0]   in_coef,
  input  logic [NUM*PIX_W-1:0]    in_pred,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [PIX_W-1:0]        out_pix,
  output logic                    out_last
);
  cblk_t coef_blk;
  cblk_t col_res;
  cblk_t row_res;
  pblk_t pix_blk;

  logic  mid_valid_q, mid_valid_d;
  cblk_t mid_res_q;
  pblk_t mid_pred_q;
  logic  mid_en;
  logic  accept;
  logic  ser_free;
  logic  ser_load;

  assign coef_blk = in_coef;

  // column pass straight from the port into the middle register
  itx4_stage #(.SHIFT(SHIFT_COL)) u_col (
    .din (coef_blk),
    .dout(col_res)
  );

  assign in_ready = !mid_valid_q || ser_free;
  assign accept   = in_valid && in_ready;
  assign ser_load = mid_valid_q && ser_free;
  assign mid_en   = accept;

  always_comb begin
    mid_valid_d = mid_valid_q;
    if (accept)        mid_valid_d = 1'b1;
    else if (ser_load) mid_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mid_valid_q <= 1'b0;
    else        mid_valid_q <= mid_valid_d;
  end

  always_ff @(posedge clk) begin
    if (mid_en) begin
      mid_res_q  <= col_res;
      mid_pred_q <= in_pred;
    end
  end

  // row pass and reconstruction from the middle register
  itx4_stage #(.SHIFT(SHIFT_ROW)) u_row (
    .din (mid_res_q),
    .dout(row_res)
  );

  itx4_recon_add u_add (
    .res (row_res),
    .pred(mid_pred_q),
    .pix (pix_blk)
  );

  itx4_serializer u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ser_load),
    .din      (pix_blk),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_pix  (out_pix),
    .out_last (out_last),
    .free     (ser_free)
  );

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> mid_valid_q); // R2
  AST_HANDOFF_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid_q && ser_free) |=> (out_valid && !out_last)); // R8
  AST_GAPLESS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && mid_valid_q) |=> out_valid); // R9
endmodule

// File: tb/test_itx4_recon.sv
module test_itx4_recon;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [255:0] in_coef;
  logic [127:0] in_pred;
  logic         out_valid;
  logic         out_ready;
  logic [7:0]   out_pix;
  logic         out_last;

  always #4 clk = ~clk;  // 125 MHz

  itx4_recon i_itx4_recon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last)
  );

  typedef struct { logic [7:0] pix; logic last; } exp_t;
  exp_t sbq[$];

  int n_chk = 0;
  int n_bad = 0;
  int ready_mode = 0;  // 0 high, 1 random, 2 low
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic void ref_line(input longint x[4], input int sh, output longint y[4]);
    longint e0, e1, o0, o1, t[4];
    e0 = 64 * (x[0] + x[2]);
    e1 = 64 * (x[0] - x[2]);
    o0 = 83 * x[1] + 36 * x[3];
    o1 = 36 * x[1] - 83 * x[3];
    t[0] = e0 + o0; t[1] = e1 + o1; t[2] = e1 - o1; t[3] = e0 - o0;
    for (int k = 0; k < 4; k++) y[k] = sat16((t[k] + (longint'(1) <<< (sh - 1))) >>> sh);
  endfunction

  // R10 packing: element (r,c) at (4r+c)*16 / (4r+c)*8
  function automatic void ref_block(input logic [255:0] c, input logic [127:0] p,
                                    output logic [7:0] px[16]);
    longint u[4][4];
    longint x[4], y[4], s;
    for (int j = 0; j < 4; j++) begin
      for (int r = 0; r < 4; r++) x[r] = longint'($signed(c[(r*4+j)*16 +: 16]));
      ref_line(x, 7, y);
      for (int k = 0; k < 4; k++) u[k][j] = y[k];
    end
    for (int i = 0; i < 4; i++) begin
      for (int r = 0; r < 4; r++) x[r] = u[i][r];
      ref_line(x, 12, y);
      for (int m = 0; m < 4; m++) begin
        s = y[m] + longint'(p[(i*4+m)*8 +: 8]);
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        px[i*4+m] = s[7:0];
      end
    end
  endfunction

  task automatic push_exp(input logic [7:0] px[16]);
    for (int i = 0; i < 16; i++) sbq.push_back('{pix: px[i], last: (i == 15)});
  endtask

  task automatic send_block(input logic [255:0] c, input logic [127:0] p);
    logic [7:0] px[16];
    ref_block(c, p, px);
    @(negedge clk);
    in_valid = 1'b1; in_coef = c; in_pred = p;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    push_exp(px);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (sbq.size() != 0 || out_valid) @(negedge clk);
  endtask

  function automatic logic [255:0] fill_coef(input logic [15:0] v);
    logic [255:0] c;
    for (int i = 0; i < 16; i++) c[i*16 +: 16] = v;
    return c;
  endfunction

  function automatic logic [127:0] fill_pred(input logic [7:0] v);
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = v;
    return p;
  endfunction

  function automatic logic [255:0] rand_coef(input bit wide);
    logic [255:0] c;
    for (int i = 0; i < 16; i++)
      c[i*16 +: 16] = wide ? 16'($urandom) : 16'($urandom_range(0, 1023) - 512);
    return c;
  endfunction

  function automatic logic [127:0] rand_pred();
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = 8'($urandom);
    return p;
  endfunction

  // output ready driver, changes just after the rising edge
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom_range(0, 3) != 0);
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    bit         stall_prev = 0;
    bit         gap_expect = 0;
    logic [7:0] pix_prev = '0;
    logic       last_prev = 1'b0;
    exp_t       e;
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        if (stall_prev) begin
          check(out_valid && out_pix == pix_prev, "R7", "stalled pixel", out_pix, pix_prev);
          check(out_last == last_prev, "R7", "stalled last", out_last, last_prev);
        end
        if (gap_expect)
          check(out_valid, "R9", "gapless next block", out_valid, 1);
        gap_expect = 0;
        if (out_valid && out_ready) begin
          if (sbq.size() == 0) begin
            check(0, "R6", "unexpected beat", out_pix, -1);
          end else begin
            e = sbq.pop_front();
            check(out_pix == e.pix, "R5", "pixel (R3/R4 transform)", out_pix, e.pix);
            check(out_last == e.last, "R6", "last marker", out_last, e.last);
            if (e.last && sbq.size() != 0) gap_expect = 1;
          end
        end
        stall_prev = out_valid && !out_ready;
        pix_prev   = out_pix;
        last_prev  = out_last;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", sbq.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]   px[16];
    logic [255:0] c;
    logic [127:0] p;
    rst_n = 1'b0; in_valid = 1'b0; in_coef = '0; in_pred = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_last == 0, "R1", "outputs after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    // R8 latency with a DC block
    ready_mode = 0;
    @(negedge clk);
    c = '0; c[15:0] = 16'sd640; p = fill_pred(8'd100);
    ref_block(c, p, px);
    in_valid = 1'b1; in_coef = c; in_pred = p;
    check(in_ready == 1, "R2", "idle ready", in_ready, 1);
    @(posedge clk);
    push_exp(px);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "R8", "no pixel after first edge", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1, "R8", "pixel after second edge", out_valid, 1);
    check(out_pix == px[0], "R8", "first pixel value", out_pix, px[0]);
    wait_idle();

    // R2 back-pressure: output blocked, two blocks fill the pipe
    ready_mode = 2;
    repeat (2) @(negedge clk);
    send_block(rand_coef(0), rand_pred());
    send_block(rand_coef(0), rand_pred());
    @(negedge clk);
    check(in_ready == 0, "R2", "ready low when full", in_ready, 0);
    repeat (5) @(negedge clk);
    check(in_ready == 0, "R2", "ready low while stalled", in_ready, 0);
    check(out_valid == 1, "R7", "valid held in stall", out_valid, 1);
    ready_mode = 1;
    wait_idle();

    // R3/R4 extremes and DC blocks under random back-pressure
    send_block(fill_coef(16'h7fff), fill_pred(8'd0));
    send_block(fill_coef(16'h8000), fill_pred(8'd255));
    send_block(fill_coef(16'h8000), fill_pred(8'd0));
    for (int i = 0; i < 16; i++) c[i*16 +: 16] = (i % 2) ? 16'h8000 : 16'h7fff;
    send_block(c, fill_pred(8'd128));
    for (int i = 0; i < 16; i++) c[i*16 +: 16] = ((i / 4) % 2) ? 16'h7fff : 16'h8000;
    send_block(c, rand_pred());
    c = '0; c[15:0] = 16'h7fff;
    send_block(c, fill_pred(8'd10));
    c = '0; c[15:0] = 16'hff80;
    send_block(c, fill_pred(8'd200));
    c = '0; c[5*16 +: 16] = 16'sd1000;
    send_block(c, fill_pred(8'd128));
    for (int n = 0; n < 40; n++) send_block(rand_coef(0), rand_pred());
    for (int n = 0; n < 20; n++) send_block(rand_coef(1), rand_pred());
    wait_idle();

    // R9 back-to-back blocks with the output always ready
    ready_mode = 0;
    @(negedge clk);
    for (int n = 0; n < 8; n++) send_block(rand_coef(0), rand_pred());
    wait_idle();
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R6", "scoreboard drained", sbq.size(), 0);
    check(out_valid == 0, "R6", "idle after drain", out_valid, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule